// File: doc/BRIEF.md
# MDIO Managed PHY Register Slave

This block is the management side of an emulated Ethernet PHY. A station manager clocks serial management frames into it over MDC and MDIO. The block runs entirely in the system clock domain. It passes both wires through a two-flop synchroniser, finds the edges of MDC, and walks each frame through its fields: preamble, start, opcode, PHY address, register address, turnaround and data. Reads take the data line and shift out sixteen bits. Writes collect sixteen bits and store them.

Behind the decoder sits a bank of thirty-two 16-bit registers with fixed reset contents. Three addresses are not read from storage. The status word and the diagnostic word follow a link input, and the link-partner word is built from the modes held in the advertisement register. A partner that always agrees with the local advertisement therefore appears fully negotiated. A separate flag compares the duplex mode that the MAC reports with the duplex the diagnostic word implies, and flags any mismatch.

Top module: `mdio_phy_emu`

## Requirements
- R1: A frame is recognised only after at least 32 consecutive rising-edge samples of MDIO equal to 1. A 0 sampled earlier than that restarts the count, and a frame preceded by fewer ones is ignored.
- R2: After the preamble, the first 0 is the first start bit and the next sample must be 1. A second start bit of 0 abandons the frame. The fields then follow MSB first on rising MDC edges: a 2-bit opcode, a 5-bit PHY address and a 5-bit register address.
- R3: After two turnaround bits, opcode binary 10 is a read and every other opcode is a write. On a read the block asserts `mdioOe` and presents the 16 data bits MSB first, changing `mdioOut` only after falling MDC edges.
- R4: On a write the block samples 16 bits on rising edges and updates the register only after the 16th bit. Registers other than 1, 5 and 18 read back the last value written.
- R5: A read whose PHY address differs from `phyAddr` returns 0xFFFF. A write with a different PHY address changes nothing.
- R6: After reset, register 0 holds 0x3100, register 2 holds 0x0300, register 3 holds 0xE400 and register 4 holds 0x01E1. Every other register holds 0.
- R7: Register 1 reads 0x782C (bits 14, 13, 12, 11, 5, 3 and 2) while `linkUp` is 1, and 0 while it is 0.
- R8: Register 5 reads 0x4001 OR (register 4 AND 0x01E0).
- R9: While `linkUp` is 1, register 18 reads bit 10 = reg4[7] OR reg4[8] and bit 11 = reg4[8] OR reg4[6], with all other bits 0. While `linkUp` is 0 it reads 0.
- R10: In each clock cycle in which `macEnable` is 1, `duplexMismatch` becomes (`macFullDuplex` != register-18 bit 11). While `macEnable` is 0 the flag holds its value.
- R11: `mdioOe` is 0 during and after reset, is released after the 16th rising edge of a read data phase, and is never asserted during a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| mdcIn | input | 1 | Management clock from the station manager |
| mdioIn | input | 1 | Management data as seen on the wire |
| phyAddr | input | 5 | PHY address this slave answers to |
| linkUp | input | 1 | Link state that feeds the status and diagnostic words |
| macEnable | input | 1 | Allows the duplex-mismatch flag to update |
| macFullDuplex | input | 1 | Duplex mode configured in the MAC |
| mdioOut | output | 1 | Read data driven toward the wire |
| mdioOe | output | 1 | Output enable for mdioOut |
| duplexMismatch | output | 1 | MAC and PHY duplex disagree |

## Verification
The bench sends a preamble that is too short and a frame whose start pattern is broken. A decoder that counted too loosely, or that skipped the start check, would commit the trailing write and corrupt register 9. It walks register 4 through half-duplex, full-duplex and 100-only advertisement values, so that a swapped bit in the register-5 or register-18 computation returns the wrong word. A foreign PHY address, opcode 11, a dropped link and a reset in the middle of a read cover the remaining corner cases: an ignored address check, a read issued for a write opcode, status bits that ignore the link, and an output enable left stuck on. Finally, the duplex flag is toggled with the enable low and then high, which catches a flag that updates when it should hold.

// File: rtl/mdio_emu_pkg.sv
package mdio_emu_pkg;
  localparam int MDIO_DATA_W = 16;
  localparam int MDIO_ADDR_W = 5;
  localparam int MDIO_OP_W   = 2;
  localparam int MDIO_HDR_W  = MDIO_OP_W + 2 * MDIO_ADDR_W;

  localparam logic [MDIO_ADDR_W-1:0] IDX_STATUS  = 5'd1;
  localparam logic [MDIO_ADDR_W-1:0] IDX_ADVERT  = 5'd4;
  localparam logic [MDIO_ADDR_W-1:0] IDX_PARTNER = 5'd5;
  localparam logic [MDIO_ADDR_W-1:0] IDX_DIAG    = 5'd18;

  typedef enum logic [2:0] {
    ST_PRE, ST_SOF, ST_HDR, ST_TA, ST_DATA
  } frameState_t;

  typedef struct packed {
    logic hdrShift;
    logic rdLoad;
    logic txShift;
    logic wrShift;
    logic commit;
    logic endFrame;
  } mdioStrobe_t;

  function automatic logic [MDIO_DATA_W-1:0] resetWord(input int idx);
    case (idx)
      0:       return 16'h3100;
      2:       return 16'h0300;
      3:       return 16'hE400;
      4:       return 16'h01E1;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/mdio_in_sync.sv
module mdio_in_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_emu_pkg::*;
#(
  parameter int PRE_MIN   = 32,
  parameter int HDR_BITS  = MDIO_HDR_W,
  parameter int DATA_BITS = MDIO_DATA_W
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        mdcRise,
  input  logic        mdcFall,
  input  logic        mdioBit,
  input  logic        isRead,
  output mdioStrobe_t stb
);
  localparam int MAX_BITS = (HDR_BITS > DATA_BITS) ? HDR_BITS : DATA_BITS;
  localparam int BIT_CW   = $clog2(MAX_BITS);
  localparam int PRE_CW   = $clog2(PRE_MIN + 1);
  localparam logic [BIT_CW-1:0] HDR_LAST  = BIT_CW'(HDR_BITS - 1);
  localparam logic [BIT_CW-1:0] DATA_LAST = BIT_CW'(DATA_BITS - 1);
  localparam logic [BIT_CW-1:0] TA_LAST   = BIT_CW'(1);
  localparam logic [PRE_CW-1:0] PRE_SAT   = PRE_CW'(PRE_MIN);

  frameState_t       state, stateNx;
  logic [BIT_CW-1:0] bitCnt, bitNx;
  logic [PRE_CW-1:0] preCnt, preNx;

  always_comb begin
    stb     = '0;
    stateNx = state;
    bitNx   = bitCnt;
    preNx   = preCnt;
    case (state)
      ST_PRE: if (mdcRise) begin
        if (mdioBit) begin
          if (preCnt != PRE_SAT) preNx = preCnt + 1'b1;
        end else begin
          preNx = '0;
          if (preCnt == PRE_SAT) stateNx = ST_SOF;
        end
      end
      ST_SOF: if (mdcRise) begin
        bitNx   = '0;
        stateNx = mdioBit ? ST_HDR : ST_PRE;
      end
      ST_HDR: if (mdcRise) begin
        stb.hdrShift = 1'b1;
        if (bitCnt == HDR_LAST) begin
          bitNx   = '0;
          stateNx = ST_TA;
        end else begin
          bitNx = bitCnt + 1'b1;
        end
      end
      ST_TA: if (mdcRise) begin
        if (bitCnt == TA_LAST) begin
          bitNx      = '0;
          stateNx    = ST_DATA;
          stb.rdLoad = isRead;
        end else begin
          bitNx = bitCnt + 1'b1;
        end
      end
      ST_DATA: begin
        if (mdcFall && isRead) stb.txShift = 1'b1;
        if (mdcRise) begin
          stb.wrShift = !isRead;
          if (bitCnt == DATA_LAST) begin
            stb.commit   = !isRead;
            stb.endFrame = 1'b1;
            bitNx        = '0;
            stateNx      = ST_PRE;
          end else begin
            bitNx = bitCnt + 1'b1;
          end
        end
      end
      default: stateNx = ST_PRE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_PRE;
      bitCnt <= '0;
      preCnt <= '0;
    end else begin
      state  <= stateNx;
      bitCnt <= bitNx;
      preCnt <= preNx;
    end
  end
endmodule

// File: rtl/mdio_reg_dp.sv
module mdio_reg_dp
  import mdio_emu_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  mdioStrobe_t            stb,
  input  logic                   mdioBit,
  input  logic [MDIO_ADDR_W-1:0] phyAddr,
  input  logic                   linkUp,
  input  logic                   macEnable,
  input  logic                   macFullDuplex,
  output logic                   isRead,
  output logic                   mdioOut,
  output logic                   mdioOe,
  output logic                   duplexMismatch
);
  localparam int REG_COUNT = 1 << MDIO_ADDR_W;
  localparam int DW        = MDIO_DATA_W;

  logic [MDIO_HDR_W-1:0]  hdrReg;
  logic [DW-1:0]          wrReg, txReg, writeWord, rdWord, storedWord;
  logic [MDIO_ADDR_W-1:0] regAddr, frameAddr;
  logic [MDIO_OP_W-1:0]   opCode;
  logic                   phyHit, wrHit;
  logic [DW-1:0]          regBank [REG_COUNT];
  logic [DW-1:0]          advWord, statusWord, partnerWord, diagWord;
  logic                   diagHundred, diagFull;

  assign opCode    = hdrReg[MDIO_HDR_W-1 -: MDIO_OP_W];
  assign frameAddr = hdrReg[2*MDIO_ADDR_W-1 -: MDIO_ADDR_W];
  assign regAddr   = hdrReg[MDIO_ADDR_W-1:0];
  assign isRead    = (opCode == 2'b10);
  assign phyHit    = (frameAddr == phyAddr);
  assign writeWord = {wrReg[DW-2:0], mdioBit};
  assign wrHit     = stb.commit && phyHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrReg <= '0;
      wrReg  <= '0;
    end else begin
      if (stb.hdrShift) hdrReg <= {hdrReg[MDIO_HDR_W-2:0], mdioBit};
      if (stb.wrShift)  wrReg  <= writeWord;
    end
  end

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                        q <= resetWord(g);
      else if (wrHit && regAddr == MDIO_ADDR_W'(g))     q <= writeWord;
    end
    assign regBank[g] = q;
  end

  // words computed on read from the advertisement register and the link
  assign advWord     = regBank[IDX_ADVERT];
  assign diagHundred = advWord[7] | advWord[8];
  assign diagFull    = advWord[8] | advWord[6];
  assign statusWord  = linkUp ? 16'h782C : '0;
  assign partnerWord = 16'h4001 | (advWord & 16'h01E0);
  assign diagWord    = linkUp ? {4'b0, diagFull, diagHundred, 10'b0} : '0;
  assign storedWord  = regBank[regAddr];

  always_comb begin
    case (regAddr)
      IDX_STATUS:  rdWord = statusWord;
      IDX_PARTNER: rdWord = partnerWord;
      IDX_DIAG:    rdWord = diagWord;
      default:     rdWord = storedWord;
    endcase
    if (!phyHit) rdWord = '1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg   <= '0;
      mdioOut <= 1'b0;
      mdioOe  <= 1'b0;
    end else begin
      if (stb.rdLoad) begin
        txReg   <= rdWord;
        mdioOut <= 1'b0;
        mdioOe  <= 1'b1;
      end else if (stb.txShift) begin
        mdioOut <= txReg[DW-1];
        txReg   <= {txReg[DW-2:0], 1'b0};
      end
      if (stb.endFrame) mdioOe <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          duplexMismatch <= 1'b0;
    else if (macEnable) duplexMismatch <= (macFullDuplex != diagWord[11]);
  end
endmodule

// File: rtl/mdio_phy_emu.sv
module mdio_phy_emu
  import mdio_emu_pkg::*;
#(
  parameter int PRE_MIN     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   mdcIn,
  input  logic                   mdioIn,
  input  logic [MDIO_ADDR_W-1:0] phyAddr,
  input  logic                   linkUp,
  input  logic                   macEnable,
  input  logic                   macFullDuplex,
  output logic                   mdioOut,
  output logic                   mdioOe,
  output logic                   duplexMismatch
);
  logic        mdcS, mdioS, mdcPrev, mdcRise, mdcFall, isReadW, commitStb;
  mdioStrobe_t stbW;

  mdio_in_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rstN (rstN),
    .din ({mdcIn, mdioIn}),
    .dout({mdcS, mdioS})
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mdcPrev <= 1'b0;
    else       mdcPrev <= mdcS;
  end

  assign mdcRise   = mdcS & ~mdcPrev;
  assign mdcFall   = ~mdcS & mdcPrev;
  assign commitStb = stbW.commit;

  mdio_frame_ctrl #(.PRE_MIN(PRE_MIN)) u_ctrl (
    .clk (clk), .rstN (rstN),
    .mdcRise (mdcRise), .mdcFall (mdcFall),
    .mdioBit (mdioS), .isRead (isReadW),
    .stb (stbW)
  );

  mdio_reg_dp u_dp (
    .clk (clk), .rstN (rstN),
    .stb (stbW), .mdioBit (mdioS),
    .phyAddr (phyAddr), .linkUp (linkUp),
    .macEnable (macEnable), .macFullDuplex (macFullDuplex),
    .isRead (isReadW), .mdioOut (mdioOut), .mdioOe (mdioOe),
    .duplexMismatch (duplexMismatch)
  );
endmodule

// File: rtl/mdio_phy_emu_chk.sv
module mdio_phy_emu_chk (
  input logic clk,
  input logic rstN,
  input logic mdioOe,
  input logic mdioOut,
  input logic isRead,
  input logic commitStb,
  input logic linkUp,
  input logic macEnable,
  input logic macFullDuplex,
  input logic duplexMismatch
);
  // R10
  dup_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !macEnable |=> $stable(duplexMismatch));

  // R9
  dup_linkdown_chk: assert property (@(posedge clk) disable iff (!rstN)
    (macEnable && !linkUp) |=> (duplexMismatch == $past(macFullDuplex)));

  // R3
  oe_read_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    mdioOe |-> isRead);

  // R4
  commit_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |-> !mdioOe);

  // R11
  out_owned_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(mdioOut) |-> mdioOe);
endmodule

bind mdio_phy_emu mdio_phy_emu_chk u_chk (
  .clk (clk), .rstN (rstN),
  .mdioOe (mdioOe), .mdioOut (mdioOut),
  .isRead (isReadW), .commitStb (commitStb),
  .linkUp (linkUp), .macEnable (macEnable),
  .macFullDuplex (macFullDuplex), .duplexMismatch (duplexMismatch)
);

// File: tb/sim_mdio_phy_emu.sv
`timescale 1ns/1ps
module sim_mdio_phy_emu;
  localparam int HALF = 6;
  localparam int NVEC = 20;
  localparam logic [4:0] MYPHY = 5'd3;
  // {write, reg, data / expected}
  localparam logic [21:0] VEC [NVEC] = '{
    {1'b0, 5'd0,  16'h3100}, {1'b0, 5'd2,  16'h0300},
    {1'b0, 5'd3,  16'hE400}, {1'b0, 5'd4,  16'h01E1},
    {1'b0, 5'd1,  16'h782C}, {1'b0, 5'd5,  16'h41E1},
    {1'b0, 5'd18, 16'h0C00}, {1'b1, 5'd4,  16'h0021},
    {1'b0, 5'd5,  16'h4021}, {1'b0, 5'd18, 16'h0000},
    {1'b1, 5'd4,  16'h0040}, {1'b0, 5'd18, 16'h0800},
    {1'b1, 5'd4,  16'h0080}, {1'b0, 5'd18, 16'h0400},
    {1'b0, 5'd5,  16'h4081}, {1'b1, 5'd9,  16'hA5C3},
    {1'b0, 5'd9,  16'hA5C3}, {1'b0, 5'd31, 16'h0000},
    {1'b1, 5'd31, 16'h8001}, {1'b0, 5'd31, 16'h8001}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mdcIn = 1'b0, mdioIn = 1'b1;
  logic [4:0] phyAddr = MYPHY;
  logic linkUp = 1'b1, macEnable = 1'b0, macFullDuplex = 1'b0;
  logic mdioOut, mdioOe, duplexMismatch;
  int applied = 0, miss = 0;

  always #4 clk = ~clk;

  mdio_phy_emu u0 (
    .clk (clk), .rstN (rstN), .mdcIn (mdcIn), .mdioIn (mdioIn),
    .phyAddr (phyAddr), .linkUp (linkUp), .macEnable (macEnable),
    .macFullDuplex (macFullDuplex), .mdioOut (mdioOut), .mdioOe (mdioOe),
    .duplexMismatch (duplexMismatch)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    applied++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bitOut(input logic v);
    mdcIn = 1'b0; mdioIn = v;
    repeat (HALF) @(negedge clk);
    mdcIn = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic header(input int preLen, input logic [1:0] st,
                        input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg);
    for (int i = 0; i < preLen; i++) bitOut(1'b1);
    bitOut(st[1]); bitOut(st[0]);
    bitOut(op[1]); bitOut(op[0]);
    for (int i = 4; i >= 0; i--) bitOut(phy[i]);
    for (int i = 4; i >= 0; i--) bitOut(rg[i]);
  endtask

  task automatic writeFrame(input int preLen, input logic [1:0] st, input logic [1:0] op,
                            input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    header(preLen, st, op, phy, rg);
    bitOut(1'b1); bitOut(1'b0);
    for (int i = 15; i >= 0; i--) bitOut(d[i]);
    mdioIn = 1'b1;
  endtask

  task automatic readFrame(input logic [4:0] phy, input logic [4:0] rg,
                           output logic [15:0] d, output logic oeAll);
    header(32, 2'b01, 2'b10, phy, rg);
    bitOut(1'b1); bitOut(1'b1);
    oeAll = 1'b1;
    d = '0;
    for (int i = 15; i >= 0; i--) begin
      mdcIn = 1'b0; mdioIn = 1'b1;
      repeat (HALF) @(negedge clk);
      d[i] = mdioOut;
      oeAll = oeAll & mdioOe;
      mdcIn = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  function automatic string reqTag(input logic [4:0] rg);
    case (rg)
      5'd1:                   return "R7";
      5'd5:                   return "R8";
      5'd18:                  return "R9";
      5'd0, 5'd2, 5'd3, 5'd4: return "R6";
      default:                return "R4";
    endcase
  endfunction

  task automatic readCheck(input string tag, input logic [4:0] phy,
                           input logic [4:0] rg, input logic [15:0] exp);
    logic [15:0] d;
    logic oeAll;
    readFrame(phy, rg, d, oeAll);
    check({"R2 R3 ", tag}, d, exp);
    check("R3 oe held through read", {15'b0, oeAll}, 16'h0001);
    check("R11 oe released after read", {15'b0, mdioOe}, 16'h0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    applied++; miss++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miss);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic oeAll;
    repeat (3) @(negedge clk);
    check("R11 oe in reset", {15'b0, mdioOe}, 16'h0000);
    check("R10 flag in reset", {15'b0, duplexMismatch}, 16'h0000);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // table walk (exactly 32 preamble ones per frame, R1 boundary)
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][21]) begin
        writeFrame(32, 2'b01, 2'b01, MYPHY, VEC[v][20:16], VEC[v][15:0]);
        check("R11 no oe on write", {15'b0, mdioOe}, 16'h0000);
      end else begin
        readCheck(reqTag(VEC[v][20:16]), MYPHY, VEC[v][20:16], VEC[v][15:0]);
      end
    end

    // R5 foreign address
    readFrame(5'd7, 5'd0, d, oeAll);
    check("R5 foreign read", d, 16'hFFFF);
    writeFrame(32, 2'b01, 2'b01, 5'd7, 5'd9, 16'h1111);
    readCheck("R5 foreign write ignored", MYPHY, 5'd9, 16'hA5C3);

    // R1 short preamble
    writeFrame(20, 2'b01, 2'b01, MYPHY, 5'd9, 16'h2222);
    readCheck("R1 short preamble ignored", MYPHY, 5'd9, 16'hA5C3);

    // R2 broken start pattern
    writeFrame(32, 2'b00, 2'b01, MYPHY, 5'd9, 16'h3333);
    readCheck("R2 bad start ignored", MYPHY, 5'd9, 16'hA5C3);

    // R3 opcode 11 is a write
    writeFrame(32, 2'b01, 2'b11, MYPHY, 5'd10, 16'h00FF);
    readCheck("R3 opcode 11 writes", MYPHY, 5'd10, 16'h00FF);

    // link down (reg4 = 0x0080)
    linkUp = 1'b0;
    readCheck("R7 link down", MYPHY, 5'd1, 16'h0000);
    readCheck("R9 link down", MYPHY, 5'd18, 16'h0000);
    readCheck("R8 link independent", MYPHY, 5'd5, 16'h4081);
    linkUp = 1'b1;

    // R10 duplex flag: reg18 bit11 = 0 now
    macEnable = 1'b1; macFullDuplex = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 mismatch set", {15'b0, duplexMismatch}, 16'h0001);
    macEnable = 1'b0; macFullDuplex = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 flag holds", {15'b0, duplexMismatch}, 16'h0001);
    macEnable = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 mismatch clear", {15'b0, duplexMismatch}, 16'h0000);
    writeFrame(32, 2'b01, 2'b01, MYPHY, 5'd4, 16'h0040);
    macFullDuplex = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 full duplex agrees", {15'b0, duplexMismatch}, 16'h0000);
    linkUp = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 R10 link down duplex", {15'b0, duplexMismatch}, 16'h0001);
    linkUp = 1'b1; macEnable = 1'b0;

    // R11 reset in the middle of a read
    header(32, 2'b01, 2'b10, MYPHY, 5'd9);
    bitOut(1'b1); bitOut(1'b1); bitOut(1'b1); bitOut(1'b1);
    check("R3 oe during read", {15'b0, mdioOe}, 16'h0001);
    rstN = 1'b0;
    @(negedge clk);
    check("R11 oe dropped by reset", {15'b0, mdioOe}, 16'h0000);
    mdcIn = 1'b0; mdioIn = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    readCheck("R6 reg9 reset to zero", MYPHY, 5'd9, 16'h0000);
    readCheck("R6 reg4 reset value", MYPHY, 5'd4, 16'h01E1);

    $display("== %0d vectors applied, %0d miscompares ==", applied, miss);
    $finish;
  end
endmodule